// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block turns a vector of already-synchronised pin levels into per-pin requests that set an interrupt status bit. Each pin carries two configuration bits. A trigger-kind bit selects edge or level detection. A polarity bit selects which edge or which level counts. A third per-pin bit switches sensing off. While sensing is off, the pin produces no requests at all.

The encoding is not symmetric. With the trigger-kind bit clear (edge), a clear polarity bit means rising and a set polarity bit means falling. With the trigger-kind bit set (level), a clear polarity bit means active-low and a set polarity bit means active-high. The surrounding controller owns the status and enable registers and the bus access. This block only produces the set requests from one registered sample per pin.

Every pin keeps its previous sample. An edge mode raises its request for exactly one cycle when that sample and the current one differ in the selected direction. A level mode raises its request on every cycle the level holds. The status therefore sets again straight after software clears it, for as long as the level persists. The request output is registered, so it reflects the inputs sampled at the preceding clock edge.

Top module: `trig_detect`

## Requirements
- R1: With trigger-kind 0 and polarity 0 (rising), `set_req[i]` is 1 for the one cycle after a clock edge at which pin i is sampled 1, provided the sample at the previous edge was 0. Otherwise it is 0.
- R2: With trigger-kind 0 and polarity 1 (falling), `set_req[i]` is 1 for the one cycle after a clock edge at which pin i is sampled 0, provided the previous sample was 1.
- R3: With trigger-kind 1 and polarity 0 (active-low), `set_req[i]` is 1 after every clock edge at which pin i is sampled 0.
- R4: With trigger-kind 1 and polarity 1 (active-high), `set_req[i]` is 1 after every clock edge at which pin i is sampled 1.
- R5: When `sense_off[i]` is sampled 1 at an edge, `set_req[i]` is 0 in the following cycle, whatever the mode and the pin level.
- R6: The previous sample keeps following the pin while sensing is off. After sensing is switched back on, an edge is reported only if the pin differs from the sample taken at the clock edge just before.
- R7: The mode bits act on the sample at the same edge. Changing the mode alone, with the pin held steady, produces no edge request.
- R8: During reset and in the cycle after reset, `set_req` is 0 for pins in an edge mode. The first sample after reset has no predecessor and cannot form an edge.
- R9: Every pin is detected independently with its own mode, polarity and sensing bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | PINS | Synchronised pin levels |
| trig_kind | input | PINS | Per pin: 0 edge, 1 level |
| trig_pol | input | PINS | Per pin polarity bit (see R1 to R4) |
| sense_off | input | PINS | Per pin: 1 disables detection |
| set_req | output | PINS | Per pin status set request, registered |

## Verification
The hardest case to reach from the ports is a switch of mode or sensing in the same cycle that the pin itself moves. In that case the stored previous sample, and not the configuration history, decides whether an edge exists. Directed sequences switch sensing back on after the pin toggled while off, and swap falling for rising with the pin held. A long run then redraws pin, mode, polarity and sensing bits every cycle from a fixed seed. This lands many of those coincidences on different pins at once, and a bench model built from the requirement table checks each one.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic prev;   // sample from the previous edge
        logic armed;  // a previous sample exists
        logic hit;    // registered set request
    } cell_state_t;
endpackage

// File: rtl/trig_mode_decode.sv
module trig_mode_decode
    import trig_pkg::*;
(
    input  logic       kind_i,
    input  logic       pol_i,
    output trig_mode_e mode_o
);
    always_comb begin
        case ({kind_i, pol_i})
            2'b00:   mode_o = TRIG_RISE;
            2'b01:   mode_o = TRIG_FALL;
            2'b10:   mode_o = TRIG_LOW;
            default: mode_o = TRIG_HIGH;
        endcase
    end
endmodule

// File: rtl/trig_pin_cell.sv
module trig_pin_cell
    import trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic kind_i,
    input  logic pol_i,
    input  logic off_i,
    output logic set_o
);
    trig_mode_e  mode;
    cell_state_t st_d, st_q;
    logic        rise_w, fall_w, cond_w;

    trig_mode_decode u_dec (
        .kind_i (kind_i),
        .pol_i  (pol_i),
        .mode_o (mode)
    );

    always_comb begin
        st_d       = st_q;
        rise_w     = st_q.armed &  pin_i & ~st_q.prev;
        fall_w     = st_q.armed & ~pin_i &  st_q.prev;
        case (mode)
            TRIG_RISE: cond_w = rise_w;
            TRIG_FALL: cond_w = fall_w;
            TRIG_LOW:  cond_w = ~pin_i;
            default:   cond_w = pin_i;
        endcase
        st_d.prev  = pin_i;        // tracks the pin even while sensing is off
        st_d.armed = 1'b1;
        st_d.hit   = cond_w & ~off_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign set_o = st_q.hit;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> !set_o); // R5
    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o && $past(!kind_i && !pol_i)) |-> $past(pin_i)); // R1
    AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o && $past(!kind_i && pol_i)) |-> !$past(pin_i)); // R2
    AST_LOW_LEVEL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i && !pol_i && !off_i && !pin_i) |=> set_o); // R3
    AST_HIGH_LEVEL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i && pol_i && !off_i && pin_i) |=> set_o); // R4
    AST_STEADY_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!kind_i && $stable(pin_i)) |=> !set_o); // R7
endmodule

// File: rtl/trig_detect.sv
module trig_detect #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_level,
    input  logic [PINS-1:0] trig_kind,
    input  logic [PINS-1:0] trig_pol,
    input  logic [PINS-1:0] sense_off,
    output logic [PINS-1:0] set_req
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        trig_pin_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_level[i]),
            .kind_i (trig_kind[i]),
            .pol_i  (trig_pol[i]),
            .off_i  (sense_off[i]),
            .set_o  (set_req[i])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (set_req == '0 || rst_n)); // R8
endmodule

// File: tb/trig_detect_test.sv
module trig_detect_test;
    localparam int PINS = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pin_level = '0, trig_kind = '0, trig_pol = '0, sense_off = '0;
    logic [PINS-1:0] set_req;

    int checks = 0, fails = 0;
    logic [PINS-1:0] m_prev = '0;
    logic            m_valid = 1'b0;

    trig_detect #(.PINS(PINS)) uut (.*);

    always #2 clk = ~clk;

    function automatic logic exp_bit(logic cur, logic prev, logic valid,
                                     logic kind, logic pol, logic off);
        logic r;
        if (off) return 1'b0;
        case ({kind, pol})
            2'b00:   r = valid & cur & ~prev;
            2'b01:   r = valid & ~cur & prev;
            2'b10:   r = ~cur;
            default: r = cur;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [PINS-1:0] act, logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: set_req actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic tick(string tag, logic [PINS-1:0] p, logic [PINS-1:0] k,
                        logic [PINS-1:0] q, logic [PINS-1:0] o);
        logic [PINS-1:0] e;
        pin_level = p; trig_kind = k; trig_pol = q; sense_off = o;
        @(negedge clk);
        for (int i = 0; i < PINS; i++)
            e[i] = exp_bit(p[i], m_prev[i], m_valid, k[i], q[i], o[i]);
        m_prev = p; m_valid = 1'b1;
        check(tag, set_req, e);
    endtask

    initial begin
        #400000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        pin_level = 8'hFF;
        repeat (3) @(negedge clk);
        check("R8 reset", set_req, '0);
        rst_n = 1'b1;
        // R8: first sample after reset, all high in rising mode: no edge
        tick("R8", 8'hFF, '0, '0, '0);
        // R1 rising
        tick("R1", 8'h00, '0, '0, '0);
        tick("R1", 8'h0F, '0, '0, '0);
        tick("R1", 8'h0F, '0, '0, '0);
        // R2 falling
        tick("R2", 8'h00, '0, 8'hFF, '0);
        tick("R2", 8'h00, '0, 8'hFF, '0);
        // R3 active-low held: repeats
        tick("R3", 8'hF0, 8'hFF, '0, '0);
        tick("R3", 8'hF0, 8'hFF, '0, '0);
        // R4 active-high held: repeats
        tick("R4", 8'hF0, 8'hFF, 8'hFF, '0);
        tick("R4", 8'hF0, 8'hFF, 8'hFF, '0);
        // R5 sensing off, all modes firing conditions
        tick("R5", 8'h0F, 8'hFF, 8'hFF, 8'hFF);
        // R6 toggle while off, then re-enable with pin held
        tick("R6", 8'h00, '0, '0, 8'hFF);
        tick("R6", 8'hFF, '0, '0, 8'hFF);
        tick("R6", 8'hFF, '0, '0, '0);
        tick("R6", 8'h00, '0, 8'hFF, '0);
        // R7 swap rising/falling with pin held
        tick("R7", 8'h00, '0, '0, '0);
        tick("R7", 8'h00, '0, 8'hFF, '0);
        tick("R7", 8'h00, '0, '0, '0);
        // R9 mixed modes per pin
        tick("R9", 8'b1010_0101, 8'b1100_1100, 8'b1010_1010, 8'b0001_0000);
        tick("R9", 8'b0101_1010, 8'b1100_1100, 8'b1010_1010, 8'b0001_0000);
        // random phase
        for (int n = 0; n < 3000; n++)
            tick("R9 random", PINS'($urandom), PINS'($urandom), PINS'($urandom),
                 PINS'($urandom) & PINS'($urandom));
        // R8 again: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset", set_req, '0);
        rst_n = 1'b1; m_valid = 1'b0;
        tick("R8", 8'hFF, '0, '0, '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule